// File: doc/BRIEF.md
# Message Buffer Write Access Guard

This block decides whether a host command to copy the input staging area into a message buffer may go ahead. It watches the command-write strobe and writes to the staging registers. Each request is judged against the controller's protocol state, the target buffer number, the sections being written (header, data), the buffer's key-slot transmit configuration, the first-dynamic-buffer boundary, a two-bit security mode and receive-queue membership. A legal command starts the transfer engine and sets the staging area's busy bit. A rejected request raises a one-clock illegal-access pulse. It does not start anything, and it leaves the busy bit as it was.

Header and receive-queue protection apply only while the controller is outside both configuration states. The busy-bit rule applies in every state.

The guard sequencer has three states:
- `G_IDLE`: the staging area is free.
- `G_LAUNCH`: a one-cycle state that drives the start pulse.
- `G_WAIT`: the transfer engine is running.

Its transitions are:
- `G_IDLE`→`G_LAUNCH` on a legal command.
- `G_LAUNCH`→`G_WAIT` always.
- `G_WAIT`→`G_IDLE` when the transfer-done input is sampled high.

Top module: `mbuf_wr_guard`

## Requirements
- R1: After reset, `busy_o`, `xfer_start_o` and `illegal_o` are all 0.
- R2: While `ctrl_state_i` is 0 (default configuration) or 1 (configuration), a command on a free staging area is legal, whatever the other inputs are.
- R3: Outside the configuration states, a command that writes the header (`wr_hdr_i`=1) of a buffer numbered below `KEY_BUFS` (default 2) while `key_tx_i`=1 is illegal. A data-only write to such a buffer is legal.
- R4: Outside the configuration states with `sec_mode_i`=2'b01, a header write to a static buffer (`buf_num_i` < `first_dyn_i`) is illegal. A header write to a buffer at or above the boundary is legal.
- R5: Outside the configuration states with `sec_mode_i[1]`=1, any header write is illegal. Data-only writes are not affected by this rule.
- R6: Outside the configuration states, a command with `wr_hdr_i` or `wr_data_i` set on a buffer with `in_rxq_i`=1 is illegal.
- R7: While `busy_o`=1, a command write or a staging-register write (`stg_wr_i`) is illegal in every protocol state. A staging-register write while free is legal and has no visible effect.
- R8: An illegal request produces no `xfer_start_o` pulse and leaves `busy_o` unchanged.
- R9: `illegal_o` is 1 for exactly the one cycle after each clock in which a request was rejected. Back-to-back rejections give back-to-back pulses.
- R10: For a legal command, `xfer_start_o` is 1 for exactly the cycle after the command. `busy_o` rises in that same cycle. `xfer_done_i` is ignored in the start cycle, and `busy_o` falls in the cycle after `xfer_done_i` is sampled in the waiting state.
- R11: Outside the configuration states with `sec_mode_i`=2'b00, a header write to a buffer that is neither key-slot nor receive-queue is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_state_i | input | 3 | Protocol state; 0 and 1 are the configuration states |
| cmd_wr_i | input | 1 | Host writes the transfer command |
| stg_wr_i | input | 1 | Host writes another staging-area register |
| buf_num_i | input | BUF_W (7) | Target message buffer number |
| wr_hdr_i | input | 1 | Command updates the header section |
| wr_data_i | input | 1 | Command updates the data section |
| key_tx_i | input | 1 | Target buffer is set to transmit in the key slot |
| first_dyn_i | input | BUF_W (7) | First dynamic buffer number |
| sec_mode_i | input | 2 | Security mode |
| in_rxq_i | input | 1 | Target buffer belongs to the receive queue |
| xfer_done_i | input | 1 | Transfer engine finished |
| busy_o | output | 1 | Staging area busy (host side) |
| xfer_start_o | output | 1 | One-cycle start pulse to the transfer engine |
| illegal_o | output | 1 | One-cycle illegal-access pulse |

## Verification
Both `xfer_start_o` and `illegal_o` go through exactly one register, so each is due in the cycle after the edge that samples the request. `busy_o` follows that same edge on a legal command. The bench drives every request on a falling edge and samples one time unit after the next rising edge, then samples again a cycle later to confirm that each pulse has ended. A transfer is completed by raising `xfer_done_i` for two edges. The first edge falls in `G_LAUNCH`, where busy must still be held. The second edge falls in `G_WAIT`, after which busy must have cleared.

// File: rtl/mbuf_guard_pkg.sv
package mbuf_guard_pkg;

    localparam int CSTATE_W = 3;

    localparam logic [CSTATE_W-1:0] CS_DEF_CFG = 3'd0;
    localparam logic [CSTATE_W-1:0] CS_CFG     = 3'd1;

    typedef enum logic [1:0] {
        G_IDLE   = 2'd0,
        G_LAUNCH = 2'd1,
        G_WAIT   = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic key_slot;
        logic sec_low;
        logic sec_high;
        logic rx_queue;
        logic busy_hit;
    } viol_t;

endpackage

// File: rtl/mbuf_guard_rules.sv
module mbuf_guard_rules
    import mbuf_guard_pkg::*;
#(
    parameter int BUF_W    = 7,
    parameter int KEY_BUFS = 2
) (
    input  logic [CSTATE_W-1:0] ctrl_state_i,
    input  logic                cmd_wr_i,
    input  logic                stg_wr_i,
    input  logic [BUF_W-1:0]    buf_num_i,
    input  logic                wr_hdr_i,
    input  logic                wr_data_i,
    input  logic                key_tx_i,
    input  logic [BUF_W-1:0]    first_dyn_i,
    input  logic [1:0]          sec_mode_i,
    input  logic                in_rxq_i,
    input  logic                busy_i,
    output viol_t               viol_o
);

    localparam logic [BUF_W-1:0] KEY_LIM = BUF_W'(KEY_BUFS);

    logic in_cfg;
    logic guarded_cmd;
    logic hdr_cmd;
    logic is_static;
    logic is_key_buf;

    always_comb begin
        in_cfg      = (ctrl_state_i == CS_DEF_CFG) || (ctrl_state_i == CS_CFG);
        guarded_cmd = cmd_wr_i && !in_cfg;
        hdr_cmd     = guarded_cmd && wr_hdr_i;
        is_static   = buf_num_i < first_dyn_i;
        is_key_buf  = buf_num_i < KEY_LIM;

        viol_o.key_slot = hdr_cmd && key_tx_i && is_key_buf;
        viol_o.sec_low  = hdr_cmd && (sec_mode_i == 2'b01) && is_static;
        viol_o.sec_high = hdr_cmd && sec_mode_i[1];
        viol_o.rx_queue = guarded_cmd && in_rxq_i && (wr_hdr_i || wr_data_i);
        viol_o.busy_hit = busy_i && (cmd_wr_i || stg_wr_i);
    end

endmodule

// File: rtl/mbuf_guard_fsm.sv
module mbuf_guard_fsm
    import mbuf_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic xfer_done_i,
    output logic busy_o,
    output logic start_o
);

    guard_state_e state_q;
    guard_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= G_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE:   if (launch_i) state_d = G_LAUNCH;
            G_LAUNCH: state_d = G_WAIT;
            G_WAIT:   if (xfer_done_i) state_d = G_IDLE;
            default:  state_d = G_IDLE;
        endcase
    end

    always_comb begin
        busy_o  = 1'b0;
        start_o = 1'b0;
        unique case (state_q)
            G_IDLE:   ;
            G_LAUNCH: begin
                busy_o  = 1'b1;
                start_o = 1'b1;
            end
            G_WAIT:   busy_o = 1'b1;
            default:  ;
        endcase
    end

    // R10
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!start_o && busy_o));

    // R10
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == G_IDLE && launch_i) |=> start_o);

endmodule

// File: rtl/mbuf_guard_pulse.sv
module mbuf_guard_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic reject_i,
    output logic pulse_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= reject_i;
        end
    end

    // R9
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(reject_i));

endmodule

// File: rtl/mbuf_wr_guard.sv
module mbuf_wr_guard
    import mbuf_guard_pkg::*;
#(
    parameter int BUF_W    = 7,
    parameter int KEY_BUFS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          ctrl_state_i,
    input  logic                cmd_wr_i,
    input  logic                stg_wr_i,
    input  logic [BUF_W-1:0]    buf_num_i,
    input  logic                wr_hdr_i,
    input  logic                wr_data_i,
    input  logic                key_tx_i,
    input  logic [BUF_W-1:0]    first_dyn_i,
    input  logic [1:0]          sec_mode_i,
    input  logic                in_rxq_i,
    input  logic                xfer_done_i,
    output logic                busy_o,
    output logic                xfer_start_o,
    output logic                illegal_o
);

    viol_t viol;
    logic  any_viol;
    logic  launch;

    mbuf_guard_rules #(
        .BUF_W    (BUF_W),
        .KEY_BUFS (KEY_BUFS)
    ) u_rules (
        .ctrl_state_i (ctrl_state_i),
        .cmd_wr_i     (cmd_wr_i),
        .stg_wr_i     (stg_wr_i),
        .buf_num_i    (buf_num_i),
        .wr_hdr_i     (wr_hdr_i),
        .wr_data_i    (wr_data_i),
        .key_tx_i     (key_tx_i),
        .first_dyn_i  (first_dyn_i),
        .sec_mode_i   (sec_mode_i),
        .in_rxq_i     (in_rxq_i),
        .busy_i       (busy_o),
        .viol_o       (viol)
    );

    always_comb begin
        any_viol = |viol;
        launch   = cmd_wr_i && !any_viol;
    end

    mbuf_guard_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .xfer_done_i (xfer_done_i),
        .busy_o      (busy_o),
        .start_o     (xfer_start_o)
    );

    mbuf_guard_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .reject_i (any_viol),
        .pulse_o  (illegal_o)
    );

    // R8
    no_start_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !xfer_start_o);

    // R7
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (cmd_wr_i || stg_wr_i)) |=> illegal_o);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cmd_wr_i && any_viol) |=> !busy_o);

endmodule

// File: tb/mbuf_wr_guard_tb.sv
`timescale 1ns/1ps
module mbuf_wr_guard_tb;

    localparam int BUF_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       ctrl_state = 3'd2;
    logic             cmd_wr = 1'b0;
    logic             stg_wr = 1'b0;
    logic [BUF_W-1:0] buf_num = '0;
    logic             wr_hdr = 1'b0;
    logic             wr_data = 1'b0;
    logic             key_tx = 1'b0;
    logic [BUF_W-1:0] first_dyn = 7'd8;
    logic [1:0]       sec_mode = 2'b00;
    logic             in_rxq = 1'b0;
    logic             xfer_done = 1'b0;
    logic             busy;
    logic             xfer_start;
    logic             illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mbuf_wr_guard #(.BUF_W(BUF_W), .KEY_BUFS(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_state_i (ctrl_state),
        .cmd_wr_i     (cmd_wr),
        .stg_wr_i     (stg_wr),
        .buf_num_i    (buf_num),
        .wr_hdr_i     (wr_hdr),
        .wr_data_i    (wr_data),
        .key_tx_i     (key_tx),
        .first_dyn_i  (first_dyn),
        .sec_mode_i   (sec_mode),
        .in_rxq_i     (in_rxq),
        .xfer_done_i  (xfer_done),
        .busy_o       (busy),
        .xfer_start_o (xfer_start),
        .illegal_o    (illegal)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic set_req(input logic [2:0] st, input int bn, input logic h,
                           input logic d, input logic key, input logic [1:0] sm,
                           input logic rq);
        ctrl_state = st;
        buf_num    = BUF_W'(bn);
        wr_hdr     = h;
        wr_data    = d;
        key_tx     = key;
        sec_mode   = sm;
        in_rxq     = rq;
    endtask

    // Issue one command from a free staging area and check the outcome.
    task automatic do_cmd(input logic exp_ill, input string tag);
        @(negedge clk);
        cmd_wr = 1'b1;
        @(posedge clk);
        #1;
        cmd_wr = 1'b0;
        chk(illegal, exp_ill, {tag, " illegal pulse"});
        chk(xfer_start, !exp_ill, {tag, " start pulse (R8/R10)"});
        chk(busy, !exp_ill, {tag, " busy after command (R8)"});
        @(posedge clk);
        #1;
        chk(illegal, 1'b0, {tag, " pulse ends (R9)"});
        chk(xfer_start, 1'b0, {tag, " start ends (R10)"});
        if (!exp_ill) begin
            xfer_done = 1'b1;
            @(posedge clk);
            #1;
            chk(busy, 1'b0, {tag, " busy clears after done (R10)"});
            xfer_done = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk(busy, 1'b0, "R1 busy at reset");
        chk(xfer_start, 1'b0, "R1 start at reset");
        chk(illegal, 1'b0, "R1 illegal at reset");
    endtask

    task automatic t_config;
        set_req(3'd0, 0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1);
        do_cmd(1'b0, "R2 default config");
        set_req(3'd1, 1, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1);
        do_cmd(1'b0, "R2 config");
    endtask

    task automatic t_key;
        set_req(3'd2, 1, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0);
        do_cmd(1'b1, "R3 key buf1 header");
        set_req(3'd2, 0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
        do_cmd(1'b0, "R3 key buf0 data only");
        set_req(3'd2, 2, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0);
        do_cmd(1'b0, "R3 buf2 header");
        set_req(3'd2, 0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        do_cmd(1'b0, "R11 buf0 no key header");
    endtask

    task automatic t_sec_low;
        first_dyn = 7'd8;
        set_req(3'd3, 7, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0);
        do_cmd(1'b1, "R4 static header");
        set_req(3'd3, 8, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0);
        do_cmd(1'b0, "R4 at boundary header");
        set_req(3'd3, 7, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0);
        do_cmd(1'b0, "R4 static data only");
    endtask

    task automatic t_sec_high;
        set_req(3'd4, 20, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);
        do_cmd(1'b1, "R5 dynamic header mode 10");
        set_req(3'd4, 3, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0);
        do_cmd(1'b1, "R5 static header mode 11");
        set_req(3'd4, 20, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0);
        do_cmd(1'b0, "R5 data only mode 10");
        set_req(3'd4, 20, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        do_cmd(1'b0, "R11 dynamic header mode 00");
    endtask

    task automatic t_rxq;
        set_req(3'd2, 40, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
        do_cmd(1'b1, "R6 queue data");
        set_req(3'd2, 40, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        do_cmd(1'b1, "R6 queue header");
    endtask

    task automatic t_back_to_back;
        set_req(3'd2, 40, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        @(negedge clk);
        cmd_wr = 1'b1;
        @(posedge clk);
        #1;
        chk(illegal, 1'b1, "R9 first of two pulses");
        @(posedge clk);
        #1;
        cmd_wr = 1'b0;
        chk(illegal, 1'b1, "R9 second of two pulses");
        @(posedge clk);
        #1;
        chk(illegal, 1'b0, "R9 pulses end");
        chk(busy, 1'b0, "R8 busy unchanged by rejects");
    endtask

    task automatic t_busy;
        // Staging writes while free are legal and invisible.
        set_req(3'd2, 20, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        stg_wr = 1'b1;
        @(posedge clk);
        #1;
        stg_wr = 1'b0;
        chk(illegal, 1'b0, "R7 staging write while free");
        chk(busy, 1'b0, "R7 free write leaves busy");
        // Legal launch, then a command during G_LAUNCH.
        @(negedge clk);
        cmd_wr = 1'b1;
        @(posedge clk);
        #1;
        chk(xfer_start, 1'b1, "R10 launch start");
        @(posedge clk);
        #1;
        cmd_wr = 1'b0;
        chk(illegal, 1'b1, "R7 command in launch cycle");
        chk(xfer_start, 1'b0, "R8 no second start");
        chk(busy, 1'b1, "R8 busy held");
        // Staging write in configuration state while busy.
        ctrl_state = 3'd1;
        stg_wr = 1'b1;
        @(posedge clk);
        #1;
        stg_wr = 1'b0;
        chk(illegal, 1'b1, "R7 staging write busy in config");
        @(posedge clk);
        #1;
        chk(illegal, 1'b0, "R9 pulse ends after busy write");
        chk(busy, 1'b1, "R10 busy until done");
        xfer_done = 1'b1;
        @(posedge clk);
        #1;
        xfer_done = 1'b0;
        chk(busy, 1'b0, "R10 done clears busy");
    endtask

    task automatic t_done_in_launch;
        set_req(3'd2, 20, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        cmd_wr = 1'b1;
        @(posedge clk);
        #1;
        cmd_wr = 1'b0;
        xfer_done = 1'b1;
        @(posedge clk);
        #1;
        chk(busy, 1'b1, "R10 done ignored in launch cycle");
        @(posedge clk);
        #1;
        xfer_done = 1'b0;
        chk(busy, 1'b0, "R10 done honoured while waiting");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_config();
        t_key();
        t_sec_low();
        t_sec_high();
        t_rxq();
        t_back_to_back();
        t_busy();
        t_done_in_launch();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule